// File: doc/BRIEF.md
# Column-RAM Sub-block Interleaver

This block reorders one coded bit stream of D bits ahead of rate matching. It treats the stream as a matrix of 32 columns and R = ceil(D/32) rows. The first F = 32R - D positions of that matrix are dummy positions. Incoming bits fill the matrix row by row, starting just after those F positions. The matrix is then emitted column by column, with the columns visited in a fixed permuted order. Each column is held in its own narrow RAM. A write of eight bits therefore enables eight neighbouring column RAMs at once, and the row address advances every four writes.

Dummy positions are never stored. Their slots keep whatever they held before. At readout the block substitutes a zero data bit for each of them and raises a NULL flag on that bit. A column read returns up to eight rows at once. When fewer than eight of those rows exist, only the valid bits are shifted into a packing register. The register releases a byte as soon as it holds eight bits, so the output is a dense stream of bytes, each with a byte of NULL flags.

A block starts with a one-cycle `i_start` pulse carrying D while the block is idle. Input and output are valid/ready streams. An input beat is taken in any cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while the block is loading. The output follows the usual rule: while `m_valid` is high and `m_ready` is low, the output byte and its flags hold. Readout begins after the last input beat and must finish before the next block can load.

Top module: `sbi_interleaver`

## Requirements
- R1: While reset is asserted, and after it until a start is taken, `m_valid` and `s_ready` are 0.
- R2: For a block of D bits (1 to 32*MAX_ROWS), R = ceil(D/32). The block emits exactly 4R output bytes, and `m_last` is 1 on the final byte and 0 on all others.
- R3: With F = 32R - D, the first input beat carries 8 - (F mod 8) bits in its low bits, and every later beat carries 8 bits, with bit 0 being the earliest. The block takes exactly 4R - floor(F/8) beats, and `s_ready` is 0 in the cycle after the last beat.
- R4: The F leading matrix positions (row 0, columns 0 to F-1) come out with NULL flag 1 and data bit 0, whatever the column RAMs held from earlier blocks. Every other bit has NULL flag 0.
- R5: Columns are visited in the 5-bit bit-reversed order of 0..31 (0, 16, 8, 24, 4, ...). Within a column, rows go from 0 to R-1. Bit 0 of `m_data` is the earliest bit, and bit k of `m_null` flags bit k of `m_data`.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_data`, `m_null`, `m_last` and `m_valid` hold; no byte is lost or repeated.
- R7: Once loading has ended, `s_ready` stays 0 until the block is idle again. `i_start` and `s_valid` asserted during readout have no effect on the block being emitted.
- R8: Cycles with `s_valid` low during loading pause the input and do not change the emitted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | One-cycle pulse that starts a block while idle |
| i_dsize | input | DW | Block size D in bits, sampled with `i_start` |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block accepts an input beat |
| s_data | input | 8 | Input bits, bit 0 earliest |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Interleaved bits, bit 0 earliest |
| m_null | output | 8 | Per-bit NULL flags for `m_data` |
| m_last | output | 1 | Marks the final byte of the block |

## Verification
The main function is tried with block sizes chosen by their dummy count and row count. These include F = 0 (full first beat) and F = 31 (first beat of one bit). They also include row counts of 1, 2, 3, 4 and 9, so that column reads return 1, 2, 3, 4, or 8 then 1 valid bits, and the largest 64-row block. An all-ones block is followed by a block with 20 dummy positions. This shows whether stale RAM contents leak into NULL slots or whether the dummies are regenerated. Input stalls, output back-pressure and a start pulse during readout are mixed into some blocks. Every emitted byte is compared against a model of the permutation, which separates ordering errors from packing and flag errors.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int NCOL = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_READ} sbi_state_e;

  // Column visited at read step j: 5-bit bit reversal of j
  function automatic logic [4:0] visit_col(input logic [4:0] j);
    logic [4:0] c;
    for (int b = 0; b < 5; b++) c[b] = j[4-b];
    return c;
  endfunction
endpackage

// File: rtl/sbi_colram.sv
module sbi_colram #(
  parameter int NGRP = 8,
  localparam int AW  = $clog2(NGRP*8),
  localparam int GW  = AW - 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [GW-1:0] rgrp,
  output logic [7:0]    rword
);
  logic [NGRP*8-1:0] mem;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  assign rword = mem[{rgrp, 3'b000} +: 8];
endmodule

// File: rtl/sbi_packer.sv
module sbi_packer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_bits,
  input  logic [7:0] in_null,
  input  logic [3:0] in_cnt,
  input  logic       in_last,
  output logic       in_accept,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic [7:0] m_null,
  output logic       m_last
);
  logic [15:0] acc_d, acc_n, ad_d, ad_n, ld_d, ld_n;
  logic [4:0]  cnt, cnt_ad;
  logic [7:0]  keep;
  logic        tail_q, drain;

  assign drain     = (cnt >= 5'd8) && (!m_valid || m_ready);
  assign cnt_ad    = drain ? cnt - 5'd8 : cnt;
  assign ad_d      = drain ? (acc_d >> 8) : acc_d;
  assign ad_n      = drain ? (acc_n >> 8) : acc_n;
  assign in_accept = in_valid && !tail_q && (cnt_ad < 5'd8);
  assign keep      = 8'(({8'b0, 8'hFF} << in_cnt) >> 8);
  assign ld_d      = {8'b0, in_bits & keep} << cnt_ad;
  assign ld_n      = {8'b0, in_null & keep} << cnt_ad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d <= '0; acc_n <= '0; cnt <= '0; tail_q <= 1'b0;
      m_valid <= 1'b0; m_data <= '0; m_null <= '0; m_last <= 1'b0;
    end else begin
      acc_d <= in_accept ? (ad_d | ld_d) : ad_d;
      acc_n <= in_accept ? (ad_n | ld_n) : ad_n;
      cnt   <= in_accept ? cnt_ad + 5'(in_cnt) : cnt_ad;
      if (in_accept && in_last) tail_q <= 1'b1;
      if (drain) begin
        m_valid <= 1'b1;
        m_data  <= acc_d[7:0];
        m_null  <= acc_n[7:0];
        m_last  <= tail_q && (cnt_ad == 5'd0);
        if (tail_q && cnt_ad == 5'd0) tail_q <= 1'b0;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_null) && $stable(m_last)));

  p_null_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_data & m_null) == 8'h00));

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd15);
endmodule

// File: rtl/sbi_interleaver.sv
module sbi_interleaver
  import sbi_pkg::*;
#(
  parameter int  MAX_ROWS = 64,
  localparam int DW = $clog2(MAX_ROWS*32 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_start,
  input  logic [DW-1:0] i_dsize,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic [7:0]    m_null,
  output logic          m_last
);
  localparam int NGRP = (MAX_ROWS + 7) / 8;
  localparam int AW   = $clog2(NGRP*8);
  localparam int GW   = AW - 3;
  localparam int RW   = $clog2(MAX_ROWS + 1);
  localparam int WGW  = $clog2(MAX_ROWS*4);

  sbi_state_e     state;
  logic [RW-1:0]  rows_q, rows_c;
  logic [4:0]     nfill_q, nfill_c, rcol_q, col;
  logic [WGW-1:0] grp_q, lastgrp_q, lastgrp_c;
  logic [GW-1:0]  rgrp_q, lastrg_q, lastrg_c;
  logic           first_q, wr, pk_acc, pk_last;
  logic [2:0]     off;
  logic [7:0]     wal, wmask, rword, nullv;
  logic [7:0]     cword [NCOL];
  logic [RW:0]    rem;
  logic [3:0]     nv;

  // Block geometry from the requested size
  assign rows_c    = RW'(((DW+1)'(i_dsize) + (DW+1)'(31)) >> 5);
  assign nfill_c   = 5'd0 - i_dsize[4:0];
  assign lastgrp_c = WGW'({rows_c, 2'b00} - 1'b1);
  assign lastrg_c  = GW'((rows_c - 1'b1) >> 3);

  // Write side: byte-wide row-major fill after the dummy positions
  assign s_ready = (state == ST_LOAD);
  assign wr      = s_ready && s_valid;
  assign off     = first_q ? nfill_q[2:0] : 3'd0;
  assign wal     = s_data << off;
  assign wmask   = 8'hFF << off;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    sbi_colram #(.NGRP(NGRP)) u_ram (
      .clk   (clk),
      .we    (wr && (grp_q[1:0] == 2'(c/8)) && wmask[c%8]),
      .waddr (AW'(grp_q >> 2)),
      .wbit  (wal[c%8]),
      .rgrp  (rgrp_q),
      .rword (cword[c])
    );
  end

  // Read side: permuted column order, up to 8 rows per read
  assign col     = visit_col(rcol_q);
  assign rword   = cword[col];
  assign rem     = {1'b0, rows_q} - (RW+1)'({rgrp_q, 3'b000});
  assign nv      = (rem >= (RW+1)'(8)) ? 4'd8 : rem[3:0];
  assign nullv   = {7'b0, (rgrp_q == '0) && (col < nfill_q)};
  assign pk_last = (rcol_q == 5'd31) && (rgrp_q == lastrg_q);

  sbi_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (state == ST_READ),
    .in_bits   (rword & ~nullv),
    .in_null   (nullv),
    .in_cnt    (nv),
    .in_last   (pk_last),
    .in_accept (pk_acc),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_null    (m_null),
    .m_last    (m_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rows_q <= '0; nfill_q <= '0; grp_q <= '0; lastgrp_q <= '0;
      lastrg_q <= '0; first_q <= 1'b0; rcol_q <= '0; rgrp_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (i_start) begin
          rows_q    <= rows_c;
          nfill_q   <= nfill_c;
          grp_q     <= WGW'(nfill_c >> 3);
          lastgrp_q <= lastgrp_c;
          lastrg_q  <= lastrg_c;
          first_q   <= 1'b1;
          state     <= ST_LOAD;
        end
        ST_LOAD: if (s_valid) begin
          first_q <= 1'b0;
          grp_q   <= grp_q + 1'b1;
          if (grp_q == lastgrp_q) begin
            state  <= ST_READ;
            rcol_q <= '0;
            rgrp_q <= '0;
          end
        end
        ST_READ: if (pk_acc) begin
          if (rgrp_q == lastrg_q) begin
            rgrp_q <= '0;
            rcol_q <= rcol_q + 1'b1;
            if (rcol_q == 5'd31) state <= ST_IDLE;
          end else begin
            rgrp_q <= rgrp_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_start && state != ST_IDLE) |=> ($stable(rows_q) && $stable(nfill_q)));

  p_load_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp_q == lastgrp_q) |=> !s_ready);

  p_ready_reset_r1: assert property (@(posedge clk) $past(!rst_n) |-> !s_ready);
endmodule

// File: tb/tb_sbi_interleaver.sv
module tb_sbi_interleaver;
  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 64;
  localparam int DW = $clog2(MAXR*32 + 1);
  localparam int NV = 9;
  // {D[15:0], seed[15:8], mode[7:0]}; mode bit0 input stalls, bit1 output back-pressure, bit2 start intrusion
  localparam logic [31:0] VEC [0:NV-1] = '{
    {16'd64,   8'd0,  8'd0}, {16'd44,   8'd5,  8'd1}, {16'd33,  8'd7,  8'd2},
    {16'd1,    8'd0,  8'd3}, {16'd90,   8'd9,  8'd0}, {16'd280, 8'd11, 8'd3},
    {16'd100,  8'd13, 8'd2}, {16'd2048, 8'd17, 8'd1}, {16'd32,  8'd19, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, i_start = 1'b0, s_valid = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] i_dsize = '0;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, m_last;
  logic [7:0] m_data, m_null;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit inb [0:2047];
  bit exd [0:2047];
  bit exn [0:2047];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbi_interleaver #(.MAX_ROWS(MAXR)) dut (
    .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_dsize(i_dsize),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_null(m_null), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_block(input int d, input int seed, input int mode);
    int r, f, nfirst, nbeats, k;
    r = (d + 31) / 32;
    f = r*32 - d;
    nfirst = 8 - (f % 8);
    nbeats = 4*r - f/8;
    for (int i = 0; i < d; i++) inb[i] = (seed == 0) ? 1'b1 : (((i*seed + i/5) % 7) < 3);
    k = 0;
    for (int j = 0; j < 32; j++) begin
      int c = 0;
      for (int b = 0; b < 5; b++) if (j[b]) c += 1 << (4-b);
      for (int row = 0; row < r; row++) begin
        int pos = row*32 + c;
        exn[k] = (pos < f);
        exd[k] = (pos < f) ? 1'b0 : inb[pos - f];
        k++;
      end
    end
    @(negedge clk);
    i_start = 1'b1; i_dsize = DW'(d);
    @(negedge clk);
    i_start = 1'b0;
    fork
      begin : drv
        int bp = 0, cyc = 0, wait_n = 0;
        for (int b = 0; b < nbeats; ) begin
          int n = (b == 0) ? nfirst : 8;
          logic [7:0] v = '0;
          for (int i = 0; i < n; i++) v[i] = inb[bp + i];
          s_data = v;
          s_valid = !((mode & 1) && (cyc % 3 == 1));
          cyc++;
          if (s_valid && s_ready) begin b++; bp += n; wait_n = 0; end
          else if (!s_ready) begin
            wait_n++;
            if (wait_n > 20) begin check(0, "R3 s_ready dropped early", b, nbeats); break; end
          end
          @(negedge clk);
        end
        s_valid = 1'b0;
        check(s_ready == 1'b0, "R3 s_ready after last beat", s_ready, 0);
        if (mode & 4) begin
          for (int i = 0; i < 3; i++) begin
            i_start = 1'b1; i_dsize = DW'(5); s_valid = 1'b1; s_data = 8'hA5;
            @(negedge clk);
            check(s_ready == 1'b0, "R7 s_ready during readout", s_ready, 0);
          end
          i_start = 1'b0; s_valid = 1'b0;
        end
      end
      begin : mon
        int got = 0, cyc = 0;
        bit held = 0;
        logic [7:0] hd, hn;
        logic hl;
        while (got < 4*r) begin
          if (held) begin
            check(m_valid && m_data == hd && m_null == hn && m_last == hl,
                  "R6 held output", {m_valid, m_last, m_data}, {1'b1, hl, hd});
          end
          m_ready = !((mode & 2) && (cyc % 4 != 3));
          cyc++;
          if (m_valid && m_ready) begin
            logic [7:0] ed, en;
            for (int i = 0; i < 8; i++) begin ed[i] = exd[got*8+i]; en[i] = exn[got*8+i]; end
            check(m_data == ed, "R5 data byte", m_data, ed);
            check(m_null == en, "R4 null flags", m_null, en);
            check(m_last == (got == 4*r - 1), "R2 last marker", m_last, got == 4*r - 1);
            got++;
            held = 0;
          end else begin
            held = m_valid;
            hd = m_data; hn = m_null; hl = m_last;
          end
          @(negedge clk);
        end
        m_ready = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R1 m_valid in reset", m_valid, 0);
    check(s_ready == 1'b0, "R1 s_ready in reset", s_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(m_valid == 1'b0 && s_ready == 1'b0, "R1 idle after reset", {m_valid, s_ready}, 0);
    // Table walk: R2 R3 R4 R5 R6 R8; the 64-bit all-ones block precedes a 20-dummy block (R4 stale RAM)
    for (int v = 0; v < NV; v++)
      run_block(int'(VEC[v][31:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    // Directed: start and input during readout are ignored (R7)
    run_block(44, 23, 4);
    run_block(90, 29, 7);
    repeat (4) @(negedge clk);
    check(m_valid == 1'b0 && s_ready == 1'b0, "R7 idle after intrusion", {m_valid, s_ready}, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule